// File: doc/BRIEF.md
# Context-Tagged Set-Associative Translation Buffer

This block turns a 32-bit virtual address into a physical address using a small set-associative cache of page mappings. Each mapping holds a virtual page number, an address-space identifier (context), and a page-table word. The page-table word carries the physical frame, a mapping-valid flag, a read-only flag, a privileged flag and eight attribute bits. A lookup is combinational against the registered entries. It gives one of three results: hit, miss or fault. On a hit it also gives the physical address, and on any match it gives the attribute bits. Context comparison can be turned off for each request, so that global mappings can match any address space.

A page walker outside this block loads new mappings through the fill port. The block chooses the way to replace by itself: the least recently used way of the selected set. Every entry carries an age counter, and the ages within a set always form a permutation of 0..WAYS-1. A hit makes the entry the youngest (WAYS-1). Only the ways that were younger than it get one step older. The way with age 0 is the next victim.

Top module: `tlb_ctx_sa`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and within each set way w holds age w. As a result the first WAYS fills of a set go to ways 0,1,2,... in order.
- R2: The set used by a lookup or a fill is the virtual page number (address bits [31:12]) modulo ENTRIES/WAYS. Its ways are the consecutive entries starting at set*WAYS, and a fill to one set never disturbs another set.
- R3: An entry matches when it is valid, its stored page number equals address bits [31:12], and either the tagged flag is 0 or its stored context equals the request context. With the tagged flag at 0 the context input has no effect. When several ways match, the lowest-numbered way is used.
- R4: A write request (write flag 1) that matches an entry whose read-only bit (page word bit 1) is set gives a fault.
- R5: A request with the privilege flag at 0 that matches an entry whose privileged bit (page word bit 2) is set gives a fault.
- R6: A match whose mapping-valid bit (page word bit 0) is clear gives a fault. A match that passes every check gives a hit with physical address {page word[31:12], vaddr[11:0]}. On any match, hit or fault, the attribute output is page word bits [11:4].
- R7: When no way matches, the result is a miss, and the physical address and attributes are zero.
- R8: The result encoding is 2'b00 miss, 2'b01 hit and 2'b10 fault. The value 2'b11 never appears.
- R9: A valid lookup that hits, in a cycle with no fill, makes the hit way's age WAYS-1 and decrements every way in the set whose age was greater than the hit way's old age. Faults and misses change no age.
- R10: A fill writes the way with age 0 in its set: the page number, the context, the page word and the valid bit. That way takes age WAYS-1 and all the other ways of the set age by one.
- R11: When a fill and a hitting valid lookup happen in the same cycle, only the fill updates state. The lookup's result is still reported in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present (enables the age update) |
| lk_vaddr | input | ADDR_W | Lookup virtual address |
| lk_ctx | input | CTX_W | Lookup context identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_priv | input | 1 | Request is privileged |
| lk_tagged | input | 1 | Compare the context when 1 |
| lk_result | output | 2 | 00 miss, 01 hit, 10 fault |
| lk_paddr | output | ADDR_W | Physical address on a hit, else 0 |
| lk_attr | output | 8 | Attribute bits of the matching entry, else 0 |
| fill_valid | input | 1 | Write a new mapping |
| fill_vaddr | input | ADDR_W | Virtual address of the new mapping |
| fill_ctx | input | CTX_W | Context of the new mapping |
| fill_pte | input | ADDR_W | Page-table word of the new mapping |

## Verification
The hardest situation to reach from the ports is a specific age order inside one set, because it only shows when a later fill evicts a chosen way. The stimulus draws page numbers from a small pool, so that a handful of sets get refilled again and again with hits between the fills. Directed sequences fill one set to capacity, touch a middle way and then fill again to expose the victim choice. A further case sends a hit and a fill in the same cycle. A bench model replays the age rules and predicts every result.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        RES_MISS  = 2'b00,
        RES_HIT   = 2'b01,
        RES_FAULT = 2'b10
    } tlb_res_e;

    localparam int PTE_MAPV  = 0;
    localparam int PTE_RDO   = 1;
    localparam int PTE_PRIV  = 2;
    localparam int ATTR_LO   = 4;
    localparam int ATTR_W    = 8;
endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp #(
    parameter int VPN_W = 20,
    parameter int CTX_W = 8
) (
    input  logic             ent_valid,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [CTX_W-1:0] ent_ctx,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic             req_tagged,
    output logic             match
);
    logic ctx_ok;

    always_comb begin
        ctx_ok = !req_tagged || (ent_ctx == req_ctx);
        match  = ent_valid && (ent_vpn == req_vpn) && ctx_ok;
    end
endmodule

// File: rtl/tlb_access_chk.sv
module tlb_access_chk
    import tlb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12
) (
    input  logic              found,
    input  logic [ADDR_W-1:0] pte,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              is_write,
    input  logic              is_priv,
    output tlb_res_e          result,
    output logic [ADDR_W-1:0] paddr,
    output logic [ATTR_W-1:0] attr
);
    logic denied;

    always_comb begin
        denied = (is_write && pte[PTE_RDO])
               || (!is_priv && pte[PTE_PRIV])
               || !pte[PTE_MAPV];
        result = RES_MISS;
        paddr  = '0;
        attr   = '0;
        if (found) begin
            attr = pte[ATTR_LO +: ATTR_W];
            if (denied) begin
                result = RES_FAULT;
            end else begin
                result = RES_HIT;
                paddr  = {pte[ADDR_W-1:PAGE_W], vaddr[PAGE_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/tlb_age_next.sv
module tlb_age_next #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [AGE_W-1:0]           sel,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] old_age;

    always_comb begin
        old_age = age_in[sel];
        for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == sel)
                age_out[w] = AGE_W'(WAYS-1);
            else if (age_in[w] > old_age)
                age_out[w] = age_in[w] - 1'b1;
            else
                age_out[w] = age_in[w];
        end
    end
endmodule

// File: rtl/tlb_ctx_sa.sv
module tlb_ctx_sa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WAYS    = 4,
    parameter int CTX_W   = 8,
    parameter int ADDR_W  = 32,
    parameter int PAGE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_write,
    input  logic              lk_priv,
    input  logic              lk_tagged,
    output logic [1:0]        lk_result,
    output logic [ADDR_W-1:0] lk_paddr,
    output logic [7:0]        lk_attr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [ADDR_W-1:0] fill_pte
);
    localparam int SETS  = ENTRIES / WAYS;
    localparam int VPN_W = ADDR_W - PAGE_W;
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // entry storage
    logic              ent_valid [ENTRIES];
    logic [VPN_W-1:0]  ent_vpn   [ENTRIES];
    logic [CTX_W-1:0]  ent_ctx   [ENTRIES];
    logic [ADDR_W-1:0] ent_pte   [ENTRIES];
    logic [AGE_W-1:0]  ent_age   [ENTRIES];

    // lookup path
    logic [VPN_W-1:0]            lk_vpn, fl_vpn;
    logic [SET_W-1:0]            lk_set, fl_set;
    logic [IDX_W-1:0]            lk_base, fl_base, hit_idx, fl_idx;
    logic [WAYS-1:0]             lk_match;
    logic [WAYS-1:0][AGE_W-1:0]  lk_ages, lk_ages_nx, fl_ages, fl_ages_nx;
    logic [AGE_W-1:0]            hit_way, fl_way;
    logic                        any_match, hit_update;
    logic [WAYS-1:0]             lk_seen;
    tlb_res_e                    res;
    logic [ATTR_W-1:0]           attr_w;

    assign lk_vpn  = lk_vaddr[ADDR_W-1:PAGE_W];
    assign fl_vpn  = fill_vaddr[ADDR_W-1:PAGE_W];
    assign lk_set  = SET_W'(lk_vpn % VPN_W'(SETS));
    assign fl_set  = SET_W'(fl_vpn % VPN_W'(SETS));
    assign lk_base = IDX_W'(lk_set) * IDX_W'(WAYS);
    assign fl_base = IDX_W'(fl_set) * IDX_W'(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [IDX_W-1:0] li, fi;
        assign li = lk_base + IDX_W'(w);
        assign fi = fl_base + IDX_W'(w);

        tlb_way_cmp #(.VPN_W(VPN_W), .CTX_W(CTX_W)) u_cmp (
            .ent_valid  (ent_valid[li]),
            .ent_vpn    (ent_vpn[li]),
            .ent_ctx    (ent_ctx[li]),
            .req_vpn    (lk_vpn),
            .req_ctx    (lk_ctx),
            .req_tagged (lk_tagged),
            .match      (lk_match[w])
        );

        assign lk_ages[w] = ent_age[li];
        assign fl_ages[w] = ent_age[fi];
    end

    // lowest matching way wins
    always_comb begin
        hit_way = '0;
        for (int w = WAYS-1; w >= 0; w--)
            if (lk_match[w]) hit_way = AGE_W'(w);
        any_match = |lk_match;
        hit_idx   = lk_base + IDX_W'(hit_way);
    end

    // victim is the oldest way (age 0)
    always_comb begin
        fl_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (fl_ages[w] == '0) fl_way = AGE_W'(w);
        fl_idx = fl_base + IDX_W'(fl_way);
    end

    tlb_access_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
        .found    (any_match),
        .pte      (ent_pte[hit_idx]),
        .vaddr    (lk_vaddr),
        .is_write (lk_write),
        .is_priv  (lk_priv),
        .result   (res),
        .paddr    (lk_paddr),
        .attr     (attr_w)
    );

    assign lk_result = res;
    assign lk_attr   = attr_w;

    tlb_age_next #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age_lk (
        .age_in  (lk_ages),
        .sel     (hit_way),
        .age_out (lk_ages_nx)
    );

    tlb_age_next #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age_fl (
        .age_in  (fl_ages),
        .sel     (fl_way),
        .age_out (fl_ages_nx)
    );

    assign hit_update = lk_valid && (res == RES_HIT) && !fill_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_valid[i] <= 1'b0;
                ent_vpn[i]   <= '0;
                ent_ctx[i]   <= '0;
                ent_pte[i]   <= '0;
                ent_age[i]   <= AGE_W'(i % WAYS);
            end
        end else if (fill_valid) begin
            ent_valid[fl_idx] <= 1'b1;
            ent_vpn[fl_idx]   <= fl_vpn;
            ent_ctx[fl_idx]   <= fill_ctx;
            ent_pte[fl_idx]   <= fill_pte;
            for (int w = 0; w < WAYS; w++)
                ent_age[fl_base + IDX_W'(w)] <= fl_ages_nx[w];
        end else if (hit_update) begin
            for (int w = 0; w < WAYS; w++)
                ent_age[lk_base + IDX_W'(w)] <= lk_ages_nx[w];
        end
    end

    always_comb begin
        lk_seen = '0;
        for (int w = 0; w < WAYS; w++)
            lk_seen[lk_ages[w]] = 1'b1;
    end

    assert_res_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_result != 2'b11);

    assert_hit_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == 2'b01) |-> (lk_paddr[PAGE_W-1:0] == lk_vaddr[PAGE_W-1:0]));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == 2'b00) |-> (lk_paddr == '0 && lk_attr == '0));

    assert_fill_young_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (ent_valid[$past(fl_idx)]
                        && ent_age[$past(fl_idx)] == AGE_W'(WAYS-1)));

    assert_hit_young_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_update |=> (ent_age[$past(hit_idx)] == AGE_W'(WAYS-1)));

    assert_age_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        &lk_seen);
endmodule

// File: tb/sim_tlb_ctx_sa.sv
`timescale 1ns/1ps
module sim_tlb_ctx_sa;
    localparam int ENTRIES = 16;
    localparam int WAYS    = 4;
    localparam int SETS    = ENTRIES / WAYS;
    localparam int CTX_W   = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, lk_priv, lk_tagged, fill_valid;
    logic [31:0] lk_vaddr, fill_vaddr, fill_pte, lk_paddr;
    logic [7:0]  lk_ctx, fill_ctx, lk_attr;
    logic [1:0]  lk_result;

    int n_checks = 0;
    int n_errors = 0;

    // reference model
    bit          m_valid [ENTRIES];
    logic [19:0] m_vpn   [ENTRIES];
    logic [7:0]  m_ctx   [ENTRIES];
    logic [31:0] m_pte   [ENTRIES];
    int          m_age   [ENTRIES];

    always #4 clk = ~clk;

    tlb_ctx_sa u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ctx(lk_ctx),
        .lk_write(lk_write), .lk_priv(lk_priv), .lk_tagged(lk_tagged),
        .lk_result(lk_result), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr),
        .fill_ctx(fill_ctx), .fill_pte(fill_pte)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 0; m_vpn[i] = '0; m_ctx[i] = '0; m_pte[i] = '0;
            m_age[i] = i % WAYS;
        end
    endfunction

    function automatic void touch(int base, int sel);
        int old = m_age[base + sel];
        for (int w = 0; w < WAYS; w++) begin
            if (w == sel) m_age[base + w] = WAYS - 1;
            else if (m_age[base + w] > old) m_age[base + w]--;
        end
    endfunction

    // one cycle: drive, check outputs, clock, update model
    task automatic step(string note, bit lv, logic [31:0] va, logic [7:0] cx,
                        bit wr, bit pv, bit tg,
                        bit fv, logic [31:0] fva, logic [7:0] fcx, logic [31:0] fpte);
        int          base, hw, res;
        logic [31:0] pa, at;
        string       tag;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_ctx = cx; lk_write = wr;
        lk_priv = pv; lk_tagged = tg;
        fill_valid = fv; fill_vaddr = fva; fill_ctx = fcx; fill_pte = fpte;
        #2;
        base = int'((va >> 12) % SETS) * WAYS;
        hw = -1;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_valid[base+w] && m_vpn[base+w] == va[31:12]
                && (!tg || m_ctx[base+w] == cx)) hw = w;
        pa = 0; at = 0;
        if (hw < 0) begin
            res = 0; tag = "R7 miss";
        end else begin
            logic [31:0] d = m_pte[base+hw];
            at = {24'h0, d[11:4]};
            if (wr && d[1])       begin res = 2; tag = "R4 read-only"; end
            else if (!pv && d[2]) begin res = 2; tag = "R5 privileged"; end
            else if (!d[0])       begin res = 2; tag = "R6 unmapped"; end
            else begin res = 1; pa = {d[31:12], va[11:0]}; tag = "R6 hit"; end
        end
        if (tg) tag = {tag, " R3 ctx"};
        tag = {note, " ", tag};
        check({tag, " R8 result"}, {30'h0, lk_result}, res);
        check({tag, " paddr"}, lk_paddr, pa);
        check({tag, " attr"}, {24'h0, lk_attr}, at);
        @(posedge clk);
        if (fv) begin
            int fb = int'((fva >> 12) % SETS) * WAYS;
            int vw = 0;
            for (int w = 0; w < WAYS; w++) if (m_age[fb+w] == 0) vw = w;
            touch(fb, vw);
            m_valid[fb+vw] = 1; m_vpn[fb+vw] = fva[31:12];
            m_ctx[fb+vw] = fcx; m_pte[fb+vw] = fpte;
        end else if (lv && res == 1) begin
            touch(base, hw);
        end
    endtask

    function automatic logic [31:0] va_of(int vpn, int off);
        return {vpn[19:0], off[11:0]};
    endfunction

    function automatic logic [31:0] pte_of(int frame, bit mv, bit ro, bit pr, int attr);
        return {frame[19:0], attr[7:0], 1'b0, pr, ro, mv};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        lk_valid = 0; lk_vaddr = 0; lk_ctx = 0; lk_write = 0; lk_priv = 0;
        lk_tagged = 0; fill_valid = 0; fill_vaddr = 0; fill_ctx = 0; fill_pte = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: everything misses after reset
        for (int v = 0; v < 8; v++)
            step("R1 reset", 1, va_of(v, 'h123), 0, 0, 1, 0, 0, 0, 0, 0);

        // R1/R10/R2: fill set 0 four times, then a fifth evicts way 0
        for (int k = 0; k < 4; k++)
            step("R1 fill", 0, 0, 0, 0, 0, 0, 1, va_of(4*k, 0), 8'h5,
                 pte_of(100+k, 1, 0, 0, k));
        step("R2 other set", 0, 0, 0, 0, 0, 0, 1, va_of(1, 0), 8'h5,
             pte_of(200, 1, 0, 0, 9));
        step("R10 fill", 0, 0, 0, 0, 0, 0, 1, va_of(16, 0), 8'h5,
             pte_of(116, 1, 0, 0, 7));
        step("R10 evicted", 1, va_of(0, 'h44), 8'h5, 0, 1, 1, 0, 0, 0, 0);
        step("R2 kept", 1, va_of(4, 'h45), 8'h5, 0, 1, 1, 0, 0, 0, 0);
        step("R2 neighbour", 1, va_of(1, 'hfff), 8'h5, 0, 0, 1, 0, 0, 0, 0);

        // R9: touch vpn 8 (was next victim), next fill must take vpn 12
        step("R9 touch", 1, va_of(8, 'h1), 8'h5, 0, 1, 0, 0, 0, 0, 0);
        step("R9 fill", 0, 0, 0, 0, 0, 0, 1, va_of(20, 0), 8'h5,
             pte_of(120, 1, 0, 0, 3));
        step("R9 survivor", 1, va_of(8, 'h2), 8'h5, 0, 1, 1, 0, 0, 0, 0);
        step("R9 victim", 1, va_of(12, 'h2), 8'h5, 0, 1, 1, 0, 0, 0, 0);

        // R3: context mismatch tagged vs untagged
        step("R3 wrong ctx", 1, va_of(8, 'h3), 8'h6, 0, 1, 1, 0, 0, 0, 0);
        step("R3 untagged", 1, va_of(8, 'h3), 8'h6, 0, 1, 0, 0, 0, 0, 0);

        // R4/R5/R6 permission faults on set 2
        step("R4 setup", 0, 0, 0, 0, 0, 0, 1, va_of(2, 0), 8'h1, pte_of(300, 1, 1, 1, 'hab));
        step("R6 setup", 0, 0, 0, 0, 0, 0, 1, va_of(6, 0), 8'h1, pte_of(301, 0, 0, 0, 'hcd));
        step("R4 write", 1, va_of(2, 'h10), 8'h1, 1, 1, 1, 0, 0, 0, 0);
        step("R5 user", 1, va_of(2, 'h10), 8'h1, 0, 0, 1, 0, 0, 0, 0);
        step("R4 read ok", 1, va_of(2, 'h10), 8'h1, 0, 1, 1, 0, 0, 0, 0);
        step("R6 unmapped", 1, va_of(6, 'h10), 8'h1, 0, 1, 1, 0, 0, 0, 0);

        // R11: hit and fill in the same cycle
        step("R11 both", 1, va_of(16, 'h7), 8'h5, 0, 1, 0, 1, va_of(24, 0), 8'h5,
             pte_of(124, 1, 0, 0, 1));
        step("R11 after", 0, 0, 0, 0, 0, 0, 1, va_of(28, 0), 8'h5, pte_of(128, 1, 0, 0, 2));
        step("R11 check", 1, va_of(16, 'h7), 8'h5, 0, 1, 1, 0, 0, 0, 0);

        // random mix over a small page pool
        for (int n = 0; n < 4000; n++) begin
            bit          fv  = ($urandom % 4) == 0;
            int          vp  = $urandom % 24;
            int          fvp = $urandom % 24;
            logic [31:0] pte = pte_of($urandom % 1024, ($urandom % 8) != 0,
                                      ($urandom % 3) == 0, ($urandom % 3) == 0,
                                      $urandom % 256);
            step("rand", ($urandom % 8) != 0, va_of(vp, $urandom % 4096),
                 8'($urandom % 3), ($urandom % 2) == 1, ($urandom % 2) == 1,
                 ($urandom % 2) == 1, fv, va_of(fvp, 0), 8'($urandom % 3), pte);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule